// File: doc/BRIEF.md
# Page-mode DRAM strobe sequencer

This block sits between a simple request/acknowledge port and an asynchronous page-mode DRAM. From a single clock it generates the row strobe, column strobe, write enable, output enable and the multiplexed address, and it drives the write data together with its output-enable. Every spacing between strobe edges is a parameter counted in clock cycles, rounded up from the nanosecond figure of the memory.

After reset the sequencer stays quiet for a power-up pause. It then runs a fixed number of warm-up refresh cycles, of the column-before-row kind or of the row-only kind as a parameter selects, and only after that raises `ready`. From then on it serves one access at a time: a read, an early write, a delayed write, or a read-modify-write. The three write forms differ only in where the write-enable edge falls relative to the column strobe. A refresh timer interleaves column-before-row refresh cycles between accesses.

A request is taken when `req` is high while the sequencer is idle. `ack` marks completion. The requester drops `req` in the cycle after `ack` and may raise it again at any later time.

Top module: `dram_seq`

## Requirements
- R1: No strobe falls until at least T_PAUSE cycles have passed since reset was released.
- R2: After the pause, exactly N_INIT refresh cycles run before `ready` rises, and no access is acknowledged before then.
- R3: In an early write (`req_mode` = 0), write enable is low for at least T_WCS cycles before the column strobe falls, and output enable stays high for the whole cycle.
- R4: Output enable is high whenever write enable is low or write data is driven. In a delayed write (`req_mode` = 1), write enable falls while the column strobe is already low.
- R5: In a read-modify-write (`req_mode` = 2 or 3), the column strobe stays low for at least T_CWD + T_CWL + T_T cycles.
- R6: In a read-modify-write, the row strobe stays low for at least T_RWD + T_RWL + T_T cycles.
- R7: Read data is captured only after the column strobe has been low for at least T_CAC cycles and the row strobe for at least T_RAC cycles. `rd_data` holds the addressed word when `ack` rises, and a read-modify-write returns the old contents.
- R8: When write enable falls while the column strobe is high, the column strobe has been high for at least T_RCH cycles.
- R9: After `ready`, a column-before-row refresh runs roughly every T_REFI cycles. A due refresh is served before a waiting request once the current access ends, so refreshes keep coming under a steady stream of requests.
- R10: `ack` is high for exactly one cycle per access. It rises with the row and column strobes for writes, and in the cycle that read data is latched for reads.
- R11: Write enable is high whenever the column strobe is low while the row strobe is high, so a refresh never enters a test mode.
- R12: While reset is asserted all strobes are high, `ack`, `ready` and `dq_oe` are low.
- R13: Data written by each write form is read back at the address formed from `req_addr`, whose upper half is the row and lower half the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when the sequencer is idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Write form: 0 early, 1 delayed, 2 or 3 read-modify-write |
| req_addr | input | 2*MW | Row in the upper half, column in the lower half |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Data read by the last read or read-modify-write |
| ready | output | 1 | Warm-up refresh cycles finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| ma | output | MW | Multiplexed row/column address |
| dq_out | output | DW | Write data toward the memory |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | DW | Data from the memory |

## Verification
The hardest case to reach from the ports is a refresh that falls due while an access is in flight and a new request is already waiting. The bench gets there by holding a steady stream of back-to-back requests across several refresh periods. It then measures the spacing between refreshes at the strobe pins. The memory model returns a poison value until the column and row access windows have elapsed, so a capture made too early shows up as wrong read data.

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int MW       = 10,
  parameter int DW       = 16,
  parameter int T_PAUSE  = 10000,
  parameter int N_INIT   = 8,
  parameter int CBR_INIT = 1,
  parameter int T_REFI   = 1560,
  parameter int T_RP     = 6,
  parameter int T_RCD    = 3,
  parameter int T_RAS    = 8,
  parameter int T_RAC    = 8,
  parameter int T_CAC    = 3,
  parameter int T_RCH    = 1,
  parameter int T_WCS    = 1,
  parameter int T_CAS    = 2,
  parameter int T_CWD    = 3,
  parameter int T_CWL    = 2,
  parameter int T_RWD    = 8,
  parameter int T_RWL    = 2,
  parameter int T_T      = 1,
  parameter int T_OEZ    = 2,
  parameter int T_CSR    = 1,
  parameter int T_RASR   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            req_wr,
  input  logic [1:0]      req_mode,
  input  logic [2*MW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            ack,
  output logic [DW-1:0]   rd_data,
  output logic            ready,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            oe_n,
  output logic [MW-1:0]   ma,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  input  logic [DW-1:0]   dq_in
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int L_PRE = mx(mx(T_RP, T_RCH), 1);
  localparam int L_RD  = mx(mx(T_CAC, T_RAC - T_RCD), mx(T_RAS - T_RCD, 1));
  localparam int L_EWC = mx(mx(T_CAS, T_RAS - T_RCD - T_WCS), 1);
  localparam int L_DW1 = mx(T_OEZ, 1);
  localparam int L_DW2 = mx(mx(T_CWL, T_RWL), mx(T_CAS - L_DW1, 1));
  localparam int L_RMA = mx(mx(T_CAC, T_RAC - T_RCD), 1);
  localparam int L_RMB = mx(mx(T_OEZ, 1), mx(T_CWD + T_T - L_RMA, T_RWD + T_T - T_RCD - L_RMA));
  localparam int L_RMC = mx(mx(T_CWL, T_RWL), 1);
  localparam int L_IRF = (CBR_INIT != 0) ? T_CSR : T_RASR;
  localparam int CNTW  = $clog2(mx(T_PAUSE, 255) + 1);
  localparam int RTW   = $clog2(T_REFI + 1);
  localparam int ICW   = $clog2(N_INIT + 1);

  typedef enum logic [3:0] {
    S_PAUSE, S_PRE, S_RFC, S_RFR, S_RRO, S_IDLE, S_ROW, S_RD,
    S_EW_SU, S_EW_CAS, S_DW_CAS, S_DW_WE, S_RM_RD, S_RM_GAP, S_RM_WE
  } st_t;

  st_t             st;
  logic [CNTW-1:0] cnt;
  logic [RTW-1:0]  ref_t;
  logic            ref_pend;
  logic [ICW-1:0]  icnt;
  logic [MW-1:0]   rrow, a_row, a_col;
  logic [DW-1:0]   wd;
  logic            a_wr;
  logic [1:0]      a_mode;
  logic            initd, wr_phase;

  function automatic logic [CNTW-1:0] cv(input int n);
    return CNTW'(n - 1);
  endfunction

  assign initd = (icnt == ICW'(N_INIT));
  assign ready = initd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_PAUSE;
      cnt      <= cv(T_PAUSE);
      ref_t    <= '0;
      ref_pend <= 1'b0;
      icnt     <= '0;
      rrow     <= '0;
      a_row    <= '0;
      a_col    <= '0;
      wd       <= '0;
      a_wr     <= 1'b0;
      a_mode   <= 2'b00;
      ack      <= 1'b0;
      rd_data  <= '0;
    end else begin
      ack <= 1'b0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_PAUSE: begin
            st  <= (CBR_INIT != 0) ? S_RFC : S_RRO;
            cnt <= cv(L_IRF);
          end
          S_RFC: begin
            st  <= S_RFR;
            cnt <= cv(T_RASR);
          end
          S_RFR, S_RRO: begin
            st  <= S_PRE;
            cnt <= cv(L_PRE);
            if (!initd) icnt <= icnt + 1'b1;
            if (st == S_RRO) rrow <= rrow + 1'b1;
          end
          S_PRE: begin
            if (!initd) begin
              st  <= (CBR_INIT != 0) ? S_RFC : S_RRO;
              cnt <= cv(L_IRF);
            end else begin
              st  <= S_IDLE;
              cnt <= '0;
            end
          end
          S_IDLE: begin
            if (ref_pend) begin
              ref_pend <= 1'b0;
              st       <= S_RFC;
              cnt      <= cv(T_CSR);
            end else if (req) begin
              a_row  <= req_addr[2*MW-1:MW];
              a_col  <= req_addr[MW-1:0];
              wd     <= req_wdata;
              a_wr   <= req_wr;
              a_mode <= req_mode;
              st     <= S_ROW;
              cnt    <= cv(T_RCD);
            end
          end
          S_ROW: begin
            if (!a_wr) begin
              st <= S_RD;     cnt <= cv(L_RD);
            end else if (a_mode[1]) begin
              st <= S_RM_RD;  cnt <= cv(L_RMA);
            end else if (a_mode[0]) begin
              st <= S_DW_CAS; cnt <= cv(L_DW1);
            end else begin
              st <= S_EW_SU;  cnt <= cv(mx(T_WCS, 1));
            end
          end
          S_RD: begin
            rd_data <= dq_in;
            ack     <= 1'b1;
            st      <= S_PRE;
            cnt     <= cv(L_PRE);
          end
          S_EW_SU:  begin st <= S_EW_CAS; cnt <= cv(L_EWC); end
          S_DW_CAS: begin st <= S_DW_WE;  cnt <= cv(L_DW2); end
          S_RM_RD: begin
            rd_data <= dq_in;
            st      <= S_RM_GAP;
            cnt     <= cv(L_RMB);
          end
          S_RM_GAP: begin st <= S_RM_WE; cnt <= cv(L_RMC); end
          S_EW_CAS, S_DW_WE, S_RM_WE: begin
            ack <= 1'b1;
            st  <= S_PRE;
            cnt <= cv(L_PRE);
          end
          default: begin st <= S_PRE; cnt <= cv(L_PRE); end
        endcase
      end
      if (initd) begin
        if (ref_t == RTW'(T_REFI - 1)) begin
          ref_t    <= '0;
          ref_pend <= 1'b1;
        end else begin
          ref_t <= ref_t + 1'b1;
        end
      end
    end
  end

  assign ras_n = !(st inside {S_RFR, S_RRO, S_ROW, S_RD, S_EW_SU, S_EW_CAS,
                              S_DW_CAS, S_DW_WE, S_RM_RD, S_RM_GAP, S_RM_WE});
  assign cas_n = !(st inside {S_RFC, S_RFR, S_RD, S_EW_CAS, S_DW_CAS, S_DW_WE,
                              S_RM_RD, S_RM_GAP, S_RM_WE});
  assign wr_phase = st inside {S_EW_SU, S_EW_CAS, S_DW_WE, S_RM_WE};
  assign we_n   = !wr_phase;
  assign dq_oe  = wr_phase;
  assign dq_out = wd;
  assign oe_n   = !(st inside {S_RD, S_RM_RD});
  assign ma = (st == S_RRO)  ? rrow :
              (st == S_IDLE) ? req_addr[2*MW-1:MW] :
              (st == S_ROW && (cnt != '0 || T_RCD == 1)) ? a_row : a_col;

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int T_PAUSE = 10000,
  parameter int N_INIT  = 8,
  parameter int T_WCS   = 1,
  parameter int T_CWD   = 3,
  parameter int T_CWL   = 2,
  parameter int T_RWD   = 8,
  parameter int T_RWL   = 2,
  parameter int T_T     = 1,
  parameter int T_RCH   = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic ack
);

  logic [31:0] since_rst;
  logic [15:0] we_lo, cas_lo, ras_lo, cas_hi;
  logic [7:0]  nras;
  logic        c_oe, c_we, r_oe, r_we, p_ras;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      we_lo <= '0; cas_lo <= '0; ras_lo <= '0; cas_hi <= '0;
      nras <= '0; p_ras <= 1'b1;
      c_oe <= 1'b0; c_we <= 1'b0; r_oe <= 1'b0; r_we <= 1'b0;
    end else begin
      if (since_rst != '1) since_rst <= since_rst + 1'b1;
      we_lo  <= we_n  ? '0 : ((we_lo  != '1) ? we_lo  + 1'b1 : we_lo);
      cas_lo <= cas_n ? '0 : ((cas_lo != '1) ? cas_lo + 1'b1 : cas_lo);
      ras_lo <= ras_n ? '0 : ((ras_lo != '1) ? ras_lo + 1'b1 : ras_lo);
      cas_hi <= !cas_n ? '0 : ((cas_hi != '1) ? cas_hi + 1'b1 : cas_hi);
      c_oe <= cas_n ? 1'b0 : (c_oe | !oe_n);
      c_we <= cas_n ? 1'b0 : (c_we | !we_n);
      r_oe <= ras_n ? 1'b0 : (r_oe | !oe_n);
      r_we <= ras_n ? 1'b0 : (r_we | !we_n);
      p_ras <= ras_n;
      if (p_ras && !ras_n && nras != '1) nras <= nras + 1'b1;
    end
  end

  p_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) || $fell(cas_n)) |-> since_rst >= 32'(T_PAUSE));

  p_init_before_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> nras >= 8'(N_INIT));

  p_early_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> we_lo >= 16'(T_WCS));

  p_oe_off_when_writing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || dq_oe) |-> oe_n);

  p_rmw_cas_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_n) && c_oe && c_we) |-> cas_lo >= 16'(T_CWD + T_CWL + T_T));

  p_rmw_ras_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && r_oe && r_we) |-> ras_lo >= 16'(T_RWD + T_RWL + T_T));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && cas_n) |-> cas_hi >= 16'(T_RCH));

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_cbr_we_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> we_n);

endmodule

bind dram_seq dram_seq_chk #(
  .T_PAUSE(T_PAUSE), .N_INIT(N_INIT), .T_WCS(T_WCS), .T_CWD(T_CWD),
  .T_CWL(T_CWL), .T_RWD(T_RWD), .T_RWL(T_RWL), .T_T(T_T), .T_RCH(T_RCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .ack(ack)
);

// File: tb/dram_seq_bench.sv
module dram_seq_bench;
  localparam int MW = 4, DW = 8;
  localparam int T_PAUSE = 25, N_INIT = 8, T_REFI = 150;
  localparam int T_RP = 3, T_RCD = 3, T_RAS = 7, T_RAC = 6, T_CAC = 2, T_RCH = 2;
  localparam int T_WCS = 2, T_CAS = 2, T_CWD = 4, T_CWL = 2, T_RWD = 8, T_RWL = 2;
  localparam int T_T = 1, T_OEZ = 1, T_CSR = 1, T_RASR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic [2*MW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ack, ready, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out, dq_in;
  logic [MW-1:0] ma;

  always #2 clk = ~clk;

  dram_seq #(
    .MW(MW), .DW(DW), .T_PAUSE(T_PAUSE), .N_INIT(N_INIT), .CBR_INIT(1), .T_REFI(T_REFI),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RAC(T_RAC), .T_CAC(T_CAC), .T_RCH(T_RCH),
    .T_WCS(T_WCS), .T_CAS(T_CAS), .T_CWD(T_CWD), .T_CWL(T_CWL), .T_RWD(T_RWD), .T_RWL(T_RWL),
    .T_T(T_T), .T_OEZ(T_OEZ), .T_CSR(T_CSR), .T_RASR(T_RASR)
  ) u_dram_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_mode(req_mode),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
    .ready(ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .ma(ma),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // memory model and port monitor
  logic [DW-1:0] mem [256];
  logic [MW-1:0] row, col;
  int cyc, first_cyc, cbr_cnt, tm_cnt, cbr_at_ready, last_cbr, max_gap;
  int we_run, cas_run, ras_run, last_lead, last_cas_lo, last_ras_lo;
  int last_cas_rise, min_hold, nodrv, clash, ack_run, max_ack;
  logic p_ras, p_cas, p_we, p_rdy, dw_in_cas;

  assign dq_in = (!ras_n && !cas_n && !oe_n && cas_run >= T_CAC && ras_run >= T_RAC)
                 ? mem[{row, col}] : 8'hEE;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      row = '0; col = '0;
      cyc = 0; first_cyc = -1; cbr_cnt = 0; tm_cnt = 0; cbr_at_ready = -1;
      last_cbr = -1; max_gap = 0; we_run = 0; cas_run = 0; ras_run = 0;
      last_lead = -1; last_cas_lo = 0; last_ras_lo = 0; last_cas_rise = 0;
      min_hold = 1000; nodrv = 0; clash = 0; ack_run = 0; max_ack = 0;
      p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1; p_rdy = 1'b0; dw_in_cas = 1'b0;
    end else begin
      cyc++;
      if (first_cyc < 0 && (!ras_n || !cas_n)) first_cyc = cyc;
      if (!ras_n && p_ras) begin
        if (!cas_n) begin
          cbr_cnt++;
          if (!we_n) tm_cnt++;
          if (ready) begin
            if (last_cbr >= 0 && cyc - last_cbr > max_gap) max_gap = cyc - last_cbr;
            last_cbr = cyc;
          end
        end else row = ma;
      end
      if (!cas_n && p_cas) begin
        if (!ras_n) col = ma;
        if (!we_n) last_lead = we_run;
      end
      if (cas_n && !p_cas) begin last_cas_lo = cas_run; last_cas_rise = cyc; end
      if (ras_n && !p_ras) last_ras_lo = ras_run;
      if (!we_n && p_we) begin
        if (cas_n && cyc - last_cas_rise < min_hold) min_hold = cyc - last_cas_rise;
        dw_in_cas = !cas_n;
      end
      if (!ras_n && !cas_n && !we_n) begin
        if (!dq_oe) nodrv++;
        mem[{row, col}] = dq_out;
      end
      if (!we_n && !oe_n) clash++;
      ack_run = ack ? ack_run + 1 : 0;
      if (ack_run > max_ack) max_ack = ack_run;
      if (ready && !p_rdy) cbr_at_ready = cbr_cnt;
      we_run  = we_n  ? 0 : we_run + 1;
      cas_run = cas_n ? 0 : cas_run + 1;
      ras_run = ras_n ? 0 : ras_run + 1;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_rdy = ready;
    end
  end

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp, input bit ok);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {wr, mode[1:0], addr[7:0], wdata[7:0], expected read[7:0]}
  localparam logic [26:0] VEC [10] = '{
    {1'b1, 2'd0, 8'h12, 8'hA5, 8'h00},
    {1'b0, 2'd0, 8'h12, 8'h00, 8'hA5},
    {1'b1, 2'd1, 8'h34, 8'h3C, 8'h00},
    {1'b0, 2'd0, 8'h34, 8'h00, 8'h3C},
    {1'b1, 2'd2, 8'h12, 8'h77, 8'hA5},
    {1'b0, 2'd0, 8'h12, 8'h00, 8'h77},
    {1'b1, 2'd0, 8'hFF, 8'h81, 8'h00},
    {1'b0, 2'd0, 8'hFF, 8'h00, 8'h81},
    {1'b1, 2'd3, 8'h00, 8'h11, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h00, 8'h11}
  };

  task automatic do_op(input logic wr, input logic [1:0] mode, input logic [7:0] addr,
                       input logic [7:0] wdat, input logic [7:0] exp);
    bit got = 1'b0;
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_mode = mode; req_addr = addr; req_wdata = wdat;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (ack) got = 1'b1;
    end
    req = 1'b0;
    chk("R10 ack seen", int'(got), 1, got);
    if (got && (!wr || mode[1]))
      chk("R7/R13 read data", int'(rd_data), int'(exp), rd_data == exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    bit got;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 ras_n", int'(ras_n), 1, ras_n);
    chk("R12 cas_n", int'(cas_n), 1, cas_n);
    chk("R12 we_n", int'(we_n), 1, we_n);
    chk("R12 ack/ready/dq_oe", int'({ack, ready, dq_oe}), 0, !ack && !ready && !dq_oe);
    rst_n = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 2000 && !got; i++) begin
      @(negedge clk);
      if (ready) got = 1'b1;
    end
    chk("R2 ready", int'(got), 1, got);
    @(negedge clk);
    chk("R1 pause", first_cyc, T_PAUSE, first_cyc >= T_PAUSE);
    chk("R2 init count", cbr_at_ready, N_INIT, cbr_at_ready == N_INIT);

    foreach (VEC[k]) begin
      do_op(VEC[k][26], VEC[k][25:24], VEC[k][23:16], VEC[k][15:8], VEC[k][7:0]);
      if (VEC[k][26] && VEC[k][25:24] == 2'd0)
        chk("R3 early lead", last_lead, T_WCS, last_lead >= T_WCS);
      if (VEC[k][26] && VEC[k][25:24] == 2'd1)
        chk("R4 delayed WE inside CAS", int'(dw_in_cas), 1, dw_in_cas);
      if (VEC[k][26] && VEC[k][25]) begin
        chk("R5 rmw cas low", last_cas_lo, T_CWD + T_CWL + T_T, last_cas_lo >= T_CWD + T_CWL + T_T);
        chk("R6 rmw ras low", last_ras_lo, T_RWD + T_RWL + T_T, last_ras_lo >= T_RWD + T_RWL + T_T);
      end
    end

    // R9: back-to-back reads across several refresh periods
    for (int n = 0; n < 40; n++) do_op(1'b0, 2'd0, 8'h34, 8'h00, 8'h3C);
    chk("R9 max refresh gap", max_gap, T_REFI + 20, max_gap > 0 && max_gap <= T_REFI + 20);
    c0 = cbr_cnt;
    repeat (600) @(negedge clk);
    chk("R9 idle refreshes", cbr_cnt - c0, 3, cbr_cnt - c0 >= 3);

    chk("R4 oe/we clash", clash, 0, clash == 0);
    chk("R4 undriven write", nodrv, 0, nodrv == 0);
    chk("R11 test mode entries", tm_cnt, 0, tm_cnt == 0);
    chk("R8 read hold", min_hold, T_RCH, min_hold >= T_RCH);
    chk("R10 ack width", max_ack, 1, max_ack == 1);

    // R12: reset in the middle of an access
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_mode = 2'd2; req_addr = 8'h55; req_wdata = 8'h66;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 mid-op strobes", int'({ras_n, cas_n, we_n}), 7, ras_n && cas_n && we_n);
    chk("R12 mid-op outputs", int'({ack, ready, dq_oe}), 0, !ack && !ready && !dq_oe);
    req = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule